// File: doc/BRIEF.md
# DRAM Bank Open-Row Command Sequencer

This block sits between an in-order request source and a DRAM command bus. It keeps, for every bank of the device, whether a row is open and which one. Each read or write request that arrives on a valid/ready handshake is turned into the shortest legal command sequence. If the target row is already open, only the column command is sent. If the bank has no open row, an activate comes first. If another row is open in that bank, a precharge, then an activate, then the column command are sent.

The request must stay stable while it waits, and it is accepted in the cycle its column command leaves the block. At that point the block reports the class the request had on arrival: row hit, closed-bank miss, or row conflict. Rows stay open after each column command (open-page policy). Per-bank timers hold back any command to a bank until the required spacing after its last precharge or activate has passed. Commands come out combinationally in the same cycle as the decision, so a hit costs zero added cycles.

Top module: `dram_row_seq`

## Requirements
- R1: A request whose row is open in its bank produces one column command (READ, code 2'b10, for req_wr_i=0; WRITE, code 2'b11, for req_wr_i=1) and is accepted in that same cycle, provided the bank's timer has expired.
- R2: A request to a bank with no open row first produces ACTIVATE (code 2'b01) with the request's row. The column command follows exactly T_RCD (3) cycles later, giving an acceptance latency of 3 cycles.
- R3: A request to a bank holding a different row produces PRECHARGE (code 2'b00). ACTIVATE follows T_RP (3) cycles later, and the column command 3 cycles after that, giving an acceptance latency of 6 cycles.
- R4: Open-row state and timers are kept per bank. Commands to one bank never change the class or timing seen by a request to another bank.
- R5: After a column command the row stays open, so a following request to the same bank and row is a hit.
- R6: No command goes to a bank earlier than T_RP cycles after a PRECHARGE, or T_RCD cycles after an ACTIVATE, to that bank. Once that wait is over, the pending request's next command is issued in the first allowed cycle.
- R7: At most one command is issued per cycle, and only while a request is valid. req_ready_o is high only in a cycle that carries that request's READ or WRITE.
- R8: cmd_bank_o equals the request bank on every command, cmd_row_o equals the request row on ACTIVATE, and cmd_col_o equals the request column on READ and WRITE.
- R9: While req_ready_o is high, acc_class_o gives the class the request had in its first valid cycle: 2'b00 hit, 2'b01 closed-bank miss, 2'b10 conflict.
- R10: Reset (rst_ni low) closes every bank. After reset, with no request, no command is issued, and the first access to any bank is a closed-bank miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present; held with stable fields until accepted |
| req_ready_o | output | 1 | Request accepted this cycle (its column command is issued) |
| req_bank_i | input | BANK_W (3) | Target bank |
| req_row_i | input | ROW_W (14) | Target row |
| req_col_i | input | COL_W (10) | Target column |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_type_o | output | 2 | 00 PRECHARGE, 01 ACTIVATE, 10 READ, 11 WRITE |
| cmd_bank_o | output | BANK_W (3) | Command bank |
| cmd_row_o | output | ROW_W (14) | Row for ACTIVATE |
| cmd_col_o | output | COL_W (10) | Column for READ/WRITE |
| acc_class_o | output | 2 | Class of the accepted request, valid with req_ready_o |

## Verification
The bench targets a conflict that comes right after a miss on the same bank. A design that reads the timer of the wrong bank, or skips the precharge wait, would send ACTIVATE too early, and a design that re-classifies on every cycle would report a conflict as a hit at acceptance. It also opens a row in one bank and then hits in another. Leaking state across banks shows up there as a wrong class or an extra activate. It checks the edge bank and all-ones row and column values, where a truncated field would change the address. Finally it resets with rows open, where a design that keeps stale row state would report a hit instead of a miss.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'b00,
    CLS_MISS     = 2'b01,
    CLS_CONFLICT = 2'b10
  } cls_e;
endpackage

// File: rtl/dram_bank_track.sv
module dram_bank_track #(
  parameter int unsigned ROW_W = 14,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RCD = 3,
  localparam int unsigned T_MAX = (T_RP > T_RCD) ? T_RP : T_RCD,
  localparam int unsigned TMR_W = $clog2(T_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rdy_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (pre_i) begin
      open_o <= 1'b0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end
  end

  // counts down to zero; zero means the bank may take a command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmr_q <= '0;
    else if (pre_i)         tmr_q <= TMR_W'(T_RP - 1);
    else if (act_i)         tmr_q <= TMR_W'(T_RCD - 1);
    else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
  end

  assign rdy_o = (tmr_q == '0);
endmodule

// File: rtl/dram_row_classify.sv
module dram_row_classify
  import dram_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] rows_i,
  input  logic [NUM_BANKS-1:0]            rdy_i,
  input  logic [BANK_W-1:0]               bank_i,
  input  logic [ROW_W-1:0]                row_i,
  output cls_e                            cls_o,
  output logic                            rdy_o
);
  logic             sel_open;
  logic [ROW_W-1:0] sel_row;

  assign sel_open = open_i[bank_i];
  assign sel_row  = rows_i[bank_i];
  assign rdy_o    = rdy_i[bank_i];

  always_comb begin
    if (!sel_open)             cls_o = CLS_MISS;
    else if (sel_row == row_i) cls_o = CLS_HIT;
    else                       cls_o = CLS_CONFLICT;
  end
endmodule

// File: rtl/dram_cmd_issue.sv
module dram_cmd_issue
  import dram_seq_pkg::*;
(
  input  logic req_valid_i,
  input  logic req_wr_i,
  input  cls_e cls_i,
  input  logic bank_rdy_i,
  output logic cmd_valid_o,
  output cmd_e cmd_type_o,
  output logic col_go_o
);
  always_comb begin
    cmd_valid_o = req_valid_i && bank_rdy_i;
    col_go_o    = 1'b0;
    cmd_type_o  = CMD_PRE;
    unique case (cls_i)
      CLS_HIT: begin
        cmd_type_o = req_wr_i ? CMD_WR : CMD_RD;
        col_go_o   = cmd_valid_o;
      end
      CLS_MISS:     cmd_type_o = CMD_ACT;
      CLS_CONFLICT: cmd_type_o = CMD_PRE;
      default:      cmd_valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RCD     = 3,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_wr_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_type_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic [1:0]        acc_class_o
);
  logic [NUM_BANKS-1:0]            bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
  logic [NUM_BANKS-1:0]            bank_rdy;
  logic [NUM_BANKS-1:0]            pre_vec;
  logic [NUM_BANKS-1:0]            act_vec;

  cls_e cur_cls;
  logic tgt_rdy;
  cmd_e cmd_type;
  logic col_go;
  logic pend_q;
  cls_e pend_cls_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign pre_vec[b] = cmd_valid_o && (cmd_type == CMD_PRE) && (req_bank_i == BANK_W'(b));
    assign act_vec[b] = cmd_valid_o && (cmd_type == CMD_ACT) && (req_bank_i == BANK_W'(b));

    dram_bank_track #(
      .ROW_W (ROW_W),
      .T_RP  (T_RP),
      .T_RCD (T_RCD)
    ) u_track (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pre_i  (pre_vec[b]),
      .act_i  (act_vec[b]),
      .row_i  (req_row_i),
      .open_o (bank_open[b]),
      .row_o  (bank_row[b]),
      .rdy_o  (bank_rdy[b])
    );
  end

  dram_row_classify #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_cls (
    .open_i (bank_open),
    .rows_i (bank_row),
    .rdy_i  (bank_rdy),
    .bank_i (req_bank_i),
    .row_i  (req_row_i),
    .cls_o  (cur_cls),
    .rdy_o  (tgt_rdy)
  );

  dram_cmd_issue u_issue (
    .req_valid_i (req_valid_i),
    .req_wr_i    (req_wr_i),
    .cls_i       (cur_cls),
    .bank_rdy_i  (tgt_rdy),
    .cmd_valid_o (cmd_valid_o),
    .cmd_type_o  (cmd_type),
    .col_go_o    (col_go)
  );

  // class seen on arrival is kept until the request is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_cls_q <= CLS_HIT;
    end else if (col_go) begin
      pend_q     <= 1'b0;
    end else if (req_valid_i && !pend_q) begin
      pend_q     <= 1'b1;
      pend_cls_q <= cur_cls;
    end
  end

  assign req_ready_o = col_go;
  assign cmd_type_o  = cmd_type;
  assign cmd_bank_o  = req_bank_i;
  assign cmd_row_o   = req_row_i;
  assign cmd_col_o   = req_col_i;
  assign acc_class_o = pend_q ? pend_cls_q : cur_cls;
endmodule

// File: rtl/dram_row_seq_chk.sv
module dram_row_seq_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RCD     = 3,
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned T_MAX  = (T_RP > T_RCD) ? T_RP : T_RCD,
  localparam int unsigned GAP_W  = $clog2(T_MAX + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ROW_W-1:0]  req_row_i,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_type_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_row_o,
  input logic [1:0]        acc_class_o
);
  logic [NUM_BANKS-1:0]            open_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_q;
  logic [NUM_BANKS-1:0][GAP_W-1:0] gap_q;
  logic [NUM_BANKS-1:0][GAP_W-1:0] need_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mon
    logic hit_b;
    assign hit_b = cmd_valid_o && (cmd_bank_o == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
        gap_q[b]  <= GAP_W'(T_MAX);
        need_q[b] <= '0;
      end else if (hit_b && cmd_type_o == 2'b00) begin
        open_q[b] <= 1'b0;
        gap_q[b]  <= GAP_W'(1);
        need_q[b] <= GAP_W'(T_RP);
      end else if (hit_b && cmd_type_o == 2'b01) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= cmd_row_o;
        gap_q[b]  <= GAP_W'(1);
        need_q[b] <= GAP_W'(T_RCD);
      end else if (gap_q[b] < GAP_W'(T_MAX)) begin
        gap_q[b]  <= gap_q[b] + 1'b1;
      end
    end
  end

  p_col_on_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cmd_valid_o && cmd_type_o[1]));

  p_cmd_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> req_valid_i);

  p_bank_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (gap_q[cmd_bank_o] >= need_q[cmd_bank_o]));

  p_act_on_closed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == 2'b01) |-> !open_q[cmd_bank_o]);

  p_pre_on_other_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o == 2'b00) |->
      (open_q[cmd_bank_o] && row_q[cmd_bank_o] != req_row_i));

  p_col_on_open_row_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_type_o[1]) |->
      (open_q[cmd_bank_o] && row_q[cmd_bank_o] == req_row_i));

  p_class_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (acc_class_o != 2'b11));
endmodule

bind dram_row_seq dram_row_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .T_RP      (T_RP),
  .T_RCD     (T_RCD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_row_i   (req_row_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_type_o  (cmd_type_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_row_o   (cmd_row_o),
  .acc_class_o (acc_class_o)
);

// File: tb/tb_dram_row_seq.sv
`timescale 1ns/1ps
module tb_dram_row_seq;
  localparam int NB = 8;
  localparam int RW = 14;
  localparam int CW = 10;
  localparam int TP = 3;
  localparam int TC = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [2:0] req_bank_i = '0;
  logic [RW-1:0] req_row_i = '0;
  logic [CW-1:0] req_col_i = '0;
  logic req_wr_i = 1'b0;
  logic cmd_valid_o;
  logic [1:0] cmd_type_o;
  logic [2:0] cmd_bank_o;
  logic [RW-1:0] cmd_row_o;
  logic [CW-1:0] cmd_col_o;
  logic [1:0] acc_class_o;

  always #2.5 clk = ~clk;

  dram_row_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_bank_i(req_bank_i), .req_row_i(req_row_i), .req_col_i(req_col_i),
    .req_wr_i(req_wr_i),
    .cmd_valid_o(cmd_valid_o), .cmd_type_o(cmd_type_o), .cmd_bank_o(cmd_bank_o),
    .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o), .acc_class_o(acc_class_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit m_open[NB];
  int m_row[NB];
  int m_rdy[NB];
  int cyc = 0;
  bit in_req = 1'b0;
  int req_cls = 0;
  int req_start = 0;
  bit accepted = 1'b0;
  int last_lat = 0;
  int last_cls = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 1'b0; m_row[b] = 0; m_rdy[b] = 0;
    end
    in_req = 1'b0;
  endtask

  function automatic string cls_tag(int c);
    if (c == 0) return "R1";
    if (c == 1) return "R2";
    return "R3";
  endfunction

  // one clock: compare at negedge, commit model, return after posedge
  task automatic step();
    int b, r, ev, et;
    bit erdy;
    @(negedge clk);
    b = int'(req_bank_i); r = int'(req_row_i);
    ev = 0; et = 0; erdy = 1'b0; accepted = 1'b0;
    if (req_valid_i) begin
      if (!in_req) begin
        in_req = 1'b1; req_start = cyc;
        req_cls = !m_open[b] ? 1 : (m_row[b] == r ? 0 : 2);
      end
      if (cyc >= m_rdy[b]) begin
        ev = 1;
        if (m_open[b] && m_row[b] == r) begin et = req_wr_i ? 3 : 2; erdy = 1'b1; end
        else if (!m_open[b]) et = 1;
        else et = 0;
      end
    end
    chk(cmd_valid_o == ev[0], (req_valid_i && cyc < m_rdy[b]) ? "R6 wait" : "R7 cmd_valid",
        int'(cmd_valid_o), ev);
    chk(req_ready_o == erdy, "R7 ready", int'(req_ready_o), int'(erdy));
    if (ev != 0) begin
      chk(int'(cmd_type_o) == et, cls_tag(req_cls), int'(cmd_type_o), et);
      chk(int'(cmd_bank_o) == b, "R8 bank", int'(cmd_bank_o), b);
      if (et == 1) chk(int'(cmd_row_o) == r, "R8 row", int'(cmd_row_o), r);
      if (et >= 2) chk(cmd_col_o == req_col_i, "R8 col", int'(cmd_col_o), int'(req_col_i));
    end
    if (erdy) chk(int'(acc_class_o) == req_cls, "R9 class", int'(acc_class_o), req_cls);
    if (ev != 0 && et == 0) begin m_open[b] = 1'b0; m_rdy[b] = cyc + TP; end
    if (ev != 0 && et == 1) begin m_open[b] = 1'b1; m_row[b] = r; m_rdy[b] = cyc + TC; end
    if (erdy) begin
      accepted = 1'b1; in_req = 1'b0;
      last_lat = cyc - req_start; last_cls = req_cls;
    end
    cyc++;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    req_valid_i = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  // exp_cls/exp_lat < 0 skips the directed checks
  task automatic run_req(int b, int r, int c, bit wr, int exp_cls, int exp_lat, string tag);
    req_valid_i = 1'b1; req_bank_i = 3'(b); req_row_i = RW'(r);
    req_col_i = CW'(c); req_wr_i = wr;
    do step(); while (!accepted);
    req_valid_i = 1'b0;
    if (exp_cls >= 0) chk(last_cls == exp_cls, {tag, " class"}, last_cls, exp_cls);
    if (exp_lat >= 0) chk(last_lat == exp_lat, {tag, " latency"}, last_lat, exp_lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R10: idle after reset
    idle(2);
    run_req(0, 5, 7, 1'b0, 1, 3, "R10 first miss / R2");
    run_req(0, 5, 8, 1'b1, 0, 0, "R1 hit / R5 row kept");
    idle(4);
    run_req(0, 9, 1, 1'b0, 2, 6, "R3 conflict");
    run_req(1, 9, 2, 1'b1, 1, 3, "R4 other bank miss");
    run_req(0, 9, 3, 1'b0, 0, 0, "R4 bank0 unaffected");
    // same-bank conflict straight after a miss
    run_req(2, 1, 4, 1'b0, 1, 3, "R2 bank2");
    run_req(2, 4, 5, 1'b1, 2, 6, "R6 back-to-back R3");
    run_req(2, 4, 6, 1'b0, 0, 0, "R5 after conflict");
    // edge field values
    run_req(7, (1 << RW) - 1, (1 << CW) - 1, 1'b1, 1, 3, "R8 max fields");
    run_req(7, (1 << RW) - 1, 0, 1'b0, 0, 0, "R8 max row hit");
    // reset with rows open
    #1 rst_ni = 1'b0;
    model_reset();
    @(posedge clk); #1 rst_ni = 1'b1;
    idle(1);
    run_req(0, 9, 2, 1'b0, 1, 3, "R10 after reset");
    run_req(7, (1 << RW) - 1, 1, 1'b0, 1, 3, "R10 bank7 closed");
    // mixed traffic compared cycle by cycle
    for (int n = 0; n < 400; n++) begin
      run_req(int'($urandom_range(NB - 1)), int'($urandom_range(3)),
              int'($urandom_range((1 << CW) - 1)), 1'($urandom_range(1)), -1, -1, "R4 mix");
      if ($urandom_range(3) == 0) idle(int'($urandom_range(3)));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule